// File: doc/BRIEF.md
# Prioritized Multi-Level Interrupt Controller

This block gathers interrupt requests from many sources arranged in numbered levels. Each level holds a 64-bit word of pending sources. A level-summary register marks every level whose word is non-zero. Three commands maintain the words: set one source bit, clear one source bit, and wipe everything at once.

Each cycle the block merges the level summary with a software request vector and resolves a single priority. Software request bits map to small priorities counted up from one, and external levels map to their own level number. Any pending external level outranks software. An interrupt is taken only if the resolved priority is above the processor's current priority and the instruction address is word aligned. A taken interrupt latches the priority and the merged request summary. A later acknowledge strobe then commits them to the visible summary and identifier registers.

Top module: `irq_level_ctrl`

## Requirements
- R1: A set command with a legal level n (n < NUM_LEVELS) and a legal source index i (i < 64) sets source i of level n. From the next clock edge, bit n of `level_sum` reads 1.
- R2: A clear command resets source i of level n. Bit n of `level_sum` returns to 0 only once every source of that level is clear.
- R3: `clr_all` zeroes all level words and `level_sum` on the next edge. It overrides any set or clear command in the same cycle.
- R4: If a set and a clear hit the same source in the same cycle, the source ends up set.
- R5: Sources 32 to 63 are set and cleared as independent bits, exactly like sources 0 to 31.
- R6: A set or clear command with level ≥ NUM_LEVELS or index ≥ 64 changes no state. It makes `cmd_err` read 1 for the one cycle after the command.
- R7: `take_int` is 0 whenever `level_sum` is zero or `pc_low` is not 2'b00.
- R8: Software request bit i, for i in 4..18, gives candidate priority i−3. The highest set bit decides the software priority.
- R9: An external level n in 20..33 with its `level_sum` bit set gives priority n. The highest such level wins and overrides any software priority. Pending levels below 20 add no priority.
- R10: The latched summary is a 34-bit vector. It holds each set software bit (4..18) and each set external level bit (20..33) at its own position, with all other bits zero.
- R11: `take_int` is 1 only when the resolved priority is non-zero and strictly greater than `cur_ipl`.
- R12: On every edge where `take_int` is 1, the priority and summary are captured and marked valid. On an edge where `ack` is 1 with a valid capture, `intid_q` and `isr_q` take the captured values and the valid mark clears, unless a new capture occurs on the same edge.
- R13: An `ack` with no valid capture leaves `isr_q` and `intid_q` unchanged. It makes `ack_err` read 1 for the one cycle after.
- R14: After reset, `level_sum`, `isr_q`, `intid_q`, `cmd_err`, `ack_err` and `take_int` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| post_en | input | 1 | Set-source command strobe |
| post_lvl | input | 6 | Level of the set command |
| post_idx | input | 7 | Source index of the set command |
| clr_en | input | 1 | Clear-source command strobe |
| clr_lvl | input | 6 | Level of the clear command |
| clr_idx | input | 7 | Source index of the clear command |
| clr_all | input | 1 | Wipe all pending sources |
| sw_req | input | 19 | Software request vector (bits 4..18 used) |
| cur_ipl | input | 6 | Current processor priority |
| pc_low | input | 2 | Two low bits of the instruction address |
| ack | input | 1 | Commit the captured interrupt info |
| take_int | output | 1 | Interrupt should be taken now |
| level_sum | output | 34 | Per-level pending summary |
| isr_q | output | 34 | Committed request summary |
| intid_q | output | 6 | Committed interrupt priority |
| cmd_err | output | 1 | Previous cycle had an out-of-range command |
| ack_err | output | 1 | Previous cycle had an acknowledge with nothing captured |

## Verification
A corrupted source word shows up at `level_sum` on the edge after the offending set or clear command. This applies most clearly to a clear that drops a summary bit while other sources of the level are still pending. A wrong scan result is visible within the same cycle as a wrong `take_int` decision, because that decision is combinational on registered state. Wrong captured information stays hidden until the next acknowledge and then appears in `isr_q` and `intid_q` one edge later. For that reason the bench always follows a taken interrupt with an acknowledge before it compares values.

// File: rtl/irq_level_pkg.sv
// Package: shared constants and helper for the interrupt level controller.
// Assumes software levels sit below external levels and do not overlap.
package irq_level_pkg;
    localparam int unsigned DEF_SRC_W   = 64;
    localparam int unsigned DEF_SW_MIN  = 4;
    localparam int unsigned DEF_SW_MAX  = 19;
    localparam int unsigned DEF_EXT_MIN = 20;
    localparam int unsigned DEF_EXT_MAX = 34;

    // Candidate priority of a software request bit.
    function automatic int unsigned sw_rank(input int unsigned bit_pos, input int unsigned base);
        return bit_pos - base + 1;
    endfunction
endpackage

// File: rtl/irq_pend_store.sv
// Pending source storage: one SRC_W-bit word per level plus a registered
// level summary. Illegal commands are dropped and flagged one cycle later.
// Assumes LVL_W and IDX_W can hold NUM_LEVELS and SRC_W respectively.
module irq_pend_store #(
    parameter int NUM_LEVELS = 34,
    parameter int SRC_W      = 64,
    parameter int LVL_W      = 6,
    parameter int IDX_W      = 7
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  post_en,
    input  logic [LVL_W-1:0]      post_lvl,
    input  logic [IDX_W-1:0]      post_idx,
    input  logic                  clr_en,
    input  logic [LVL_W-1:0]      clr_lvl,
    input  logic [IDX_W-1:0]      clr_idx,
    input  logic                  clr_all,
    output logic [NUM_LEVELS-1:0] level_sum,
    output logic                  cmd_err
);
    localparam logic [LVL_W-1:0] LVL_LIM = LVL_W'(NUM_LEVELS);
    localparam logic [IDX_W-1:0] IDX_LIM = IDX_W'(SRC_W);
    localparam logic [SRC_W-1:0] ONE_HOT = SRC_W'(1);

    logic             post_ok, clr_ok;
    logic [SRC_W-1:0] post_mask, clr_mask;
    logic [NUM_LEVELS-1:0] sum_d;

    // Range-check commands and build full-width source masks.
    always_comb begin
        post_ok   = post_en && (post_lvl < LVL_LIM) && (post_idx < IDX_LIM);
        clr_ok    = clr_en && (clr_lvl < LVL_LIM) && (clr_idx < IDX_LIM);
        post_mask = ONE_HOT << post_idx;
        clr_mask  = ONE_HOT << clr_idx;
    end

    for (genvar g = 0; g < NUM_LEVELS; g++) begin : g_level
        logic [SRC_W-1:0] word_q, word_d;

        // Next word: clear first, set wins, wipe overrides both.
        always_comb begin
            word_d = word_q;
            if (clr_ok && clr_lvl == LVL_W'(g))
                word_d = word_d & ~clr_mask;
            if (post_ok && post_lvl == LVL_W'(g))
                word_d = word_d | post_mask;
            if (clr_all)
                word_d = '0;
        end

        // Hold the pending word of this level.
        always_ff @(posedge clk) begin
            if (!rst_n) word_q <= '0;
            else        word_q <= word_d;
        end

        assign sum_d[g] = |word_d;
    end

    // Register the level summary and the command error pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_sum <= '0;
            cmd_err   <= 1'b0;
        end else begin
            level_sum <= sum_d;
            cmd_err   <= (post_en && !post_ok) || (clr_en && !clr_ok);
        end
    end
endmodule

// File: rtl/irq_prio_resolve.sv
// Priority resolver: scans software then external ranges in ascending order,
// so the highest set bit of the later range wins. Purely combinational.
// Assumes SW_MAX <= EXT_MIN and EXT_MAX <= NUM_LEVELS.
module irq_prio_resolve
    import irq_level_pkg::*;
#(
    parameter int NUM_LEVELS = 34,
    parameter int SW_MIN     = 4,
    parameter int SW_MAX     = 19,
    parameter int EXT_MIN    = 20,
    parameter int EXT_MAX    = 34,
    parameter int PRI_W      = 6
) (
    input  logic [SW_MAX-1:0]     sw_req,
    input  logic [NUM_LEVELS-1:0] level_sum,
    output logic [PRI_W-1:0]      pri,
    output logic [NUM_LEVELS-1:0] res_sum
);
    // Walk both ranges, later hits override earlier priority.
    always_comb begin
        pri     = '0;
        res_sum = '0;
        for (int i = SW_MIN; i < SW_MAX; i++) begin
            if (sw_req[i]) begin
                pri        = PRI_W'(sw_rank(i, SW_MIN));
                res_sum[i] = 1'b1;
            end
        end
        for (int i = EXT_MIN; i < EXT_MAX; i++) begin
            if (level_sum[i]) begin
                pri        = PRI_W'(i);
                res_sum[i] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/irq_info_latch.sv
// Two-phase info holder: captures priority and summary whenever an interrupt
// is taken, and commits them to the visible registers on acknowledge.
// Assumes take and ack are synchronous single-cycle qualifiers.
module irq_info_latch #(
    parameter int NUM_LEVELS = 34,
    parameter int PRI_W      = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  take,
    input  logic [PRI_W-1:0]      pri,
    input  logic [NUM_LEVELS-1:0] res_sum,
    input  logic                  ack,
    output logic [NUM_LEVELS-1:0] isr_q,
    output logic [PRI_W-1:0]      intid_q,
    output logic                  pend_valid,
    output logic                  ack_err
);
    logic [NUM_LEVELS-1:0] hold_sum;
    logic [PRI_W-1:0]      hold_pri;

    // Capture on take; commit and drop the valid mark on ack.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_sum   <= '0;
            hold_pri   <= '0;
            pend_valid <= 1'b0;
            isr_q      <= '0;
            intid_q    <= '0;
            ack_err    <= 1'b0;
        end else begin
            ack_err <= ack && !pend_valid;
            if (ack && pend_valid) begin
                isr_q      <= hold_sum;
                intid_q    <= hold_pri;
                pend_valid <= 1'b0;
            end
            if (take) begin
                hold_sum   <= res_sum;
                hold_pri   <= pri;
                pend_valid <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/irq_level_ctrl.sv
// Top of the multi-level interrupt controller. Joins the pending store, the
// priority resolver and the info latch, and forms the take decision from the
// level summary, the instruction address alignment and the current priority.
// Assumes all inputs are synchronous to clk.
module irq_level_ctrl
    import irq_level_pkg::*;
#(
    parameter int SRC_W   = DEF_SRC_W,
    parameter int SW_MIN  = DEF_SW_MIN,
    parameter int SW_MAX  = DEF_SW_MAX,
    parameter int EXT_MIN = DEF_EXT_MIN,
    parameter int EXT_MAX = DEF_EXT_MAX,
    localparam int NUM_LEVELS = EXT_MAX,
    localparam int LVL_W      = $clog2(NUM_LEVELS + 1),
    localparam int IDX_W      = $clog2(SRC_W + 1),
    localparam int PRI_W      = $clog2(EXT_MAX + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  post_en,
    input  logic [LVL_W-1:0]      post_lvl,
    input  logic [IDX_W-1:0]      post_idx,
    input  logic                  clr_en,
    input  logic [LVL_W-1:0]      clr_lvl,
    input  logic [IDX_W-1:0]      clr_idx,
    input  logic                  clr_all,
    input  logic [SW_MAX-1:0]     sw_req,
    input  logic [PRI_W-1:0]      cur_ipl,
    input  logic [1:0]            pc_low,
    input  logic                  ack,
    output logic                  take_int,
    output logic [NUM_LEVELS-1:0] level_sum,
    output logic [NUM_LEVELS-1:0] isr_q,
    output logic [PRI_W-1:0]      intid_q,
    output logic                  cmd_err,
    output logic                  ack_err
);
    logic [PRI_W-1:0]      pri;
    logic [NUM_LEVELS-1:0] res_sum;
    logic                  pend_valid;

    irq_pend_store #(
        .NUM_LEVELS(NUM_LEVELS), .SRC_W(SRC_W), .LVL_W(LVL_W), .IDX_W(IDX_W)
    ) u_store (
        .clk(clk), .rst_n(rst_n),
        .post_en(post_en), .post_lvl(post_lvl), .post_idx(post_idx),
        .clr_en(clr_en), .clr_lvl(clr_lvl), .clr_idx(clr_idx),
        .clr_all(clr_all), .level_sum(level_sum), .cmd_err(cmd_err)
    );

    irq_prio_resolve #(
        .NUM_LEVELS(NUM_LEVELS), .SW_MIN(SW_MIN), .SW_MAX(SW_MAX),
        .EXT_MIN(EXT_MIN), .EXT_MAX(EXT_MAX), .PRI_W(PRI_W)
    ) u_resolve (
        .sw_req(sw_req), .level_sum(level_sum), .pri(pri), .res_sum(res_sum)
    );

    // Take only with pending levels, aligned address and a higher priority.
    always_comb begin
        take_int = (|level_sum) && (pc_low == 2'b00)
                && (pri != '0) && (pri > cur_ipl);
    end

    irq_info_latch #(
        .NUM_LEVELS(NUM_LEVELS), .PRI_W(PRI_W)
    ) u_info (
        .clk(clk), .rst_n(rst_n), .take(take_int), .pri(pri),
        .res_sum(res_sum), .ack(ack), .isr_q(isr_q), .intid_q(intid_q),
        .pend_valid(pend_valid), .ack_err(ack_err)
    );
endmodule

// File: rtl/irq_level_ctrl_chk.sv
// Checker for irq_level_ctrl: temporal properties over ports and the
// capture-valid mark. Attached through the bind at the end of this file.
module irq_level_ctrl_chk #(
    parameter int NUM_LEVELS = 34,
    parameter int SRC_W      = 64,
    parameter int LVL_W      = 6,
    parameter int IDX_W      = 7,
    parameter int PRI_W      = 6
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  post_en,
    input logic [LVL_W-1:0]      post_lvl,
    input logic [IDX_W-1:0]      post_idx,
    input logic                  clr_en,
    input logic                  clr_all,
    input logic                  ack,
    input logic [PRI_W-1:0]      cur_ipl,
    input logic [1:0]            pc_low,
    input logic                  take_int,
    input logic [NUM_LEVELS-1:0] level_sum,
    input logic [NUM_LEVELS-1:0] isr_q,
    input logic [PRI_W-1:0]      intid_q,
    input logic                  cmd_err,
    input logic                  ack_err,
    input logic                  pend_valid
);
    localparam logic [LVL_W-1:0] LVL_LIM = LVL_W'(NUM_LEVELS);
    localparam logic [IDX_W-1:0] IDX_LIM = IDX_W'(SRC_W);
    localparam logic [PRI_W-1:0] TOP_PRI = PRI_W'(NUM_LEVELS - 1);

    a_r1_post_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (post_en && post_lvl < LVL_LIM && post_idx < IDX_LIM && !clr_all)
        |=> level_sum[$past(post_lvl)]);

    a_r3_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
        clr_all |=> (level_sum == '0));

    a_r6_bad_post: assert property (@(posedge clk) disable iff (!rst_n)
        (post_en && post_lvl >= LVL_LIM && !clr_en && !clr_all)
        |=> (cmd_err && $stable(level_sum)));

    a_r7_qualify: assert property (@(posedge clk) disable iff (!rst_n)
        take_int |-> (level_sum != '0 && pc_low == 2'b00));

    a_r11_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_ipl >= TOP_PRI) |-> !take_int);

    a_r12_capture: assert property (@(posedge clk) disable iff (!rst_n)
        take_int |=> pend_valid);

    a_r12_commit: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && pend_valid) |=> (intid_q != '0 && !ack_err));

    a_r13_bad_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !pend_valid) |=> (ack_err && $stable(isr_q) && $stable(intid_q)));
endmodule

bind irq_level_ctrl irq_level_ctrl_chk #(
    .NUM_LEVELS(NUM_LEVELS), .SRC_W(SRC_W), .LVL_W(LVL_W),
    .IDX_W(IDX_W), .PRI_W(PRI_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .post_en(post_en), .post_lvl(post_lvl),
    .post_idx(post_idx), .clr_en(clr_en), .clr_all(clr_all), .ack(ack),
    .cur_ipl(cur_ipl), .pc_low(pc_low), .take_int(take_int),
    .level_sum(level_sum), .isr_q(isr_q), .intid_q(intid_q),
    .cmd_err(cmd_err), .ack_err(ack_err), .pend_valid(pend_valid)
);

// File: tb/irq_level_ctrl_test.sv
`timescale 1ns/1ps
// Bench for irq_level_ctrl: a vector table for resolution and take decisions,
// then directed tests for storage, ordering, errors and the commit phase.
module irq_level_ctrl_test;
    localparam int LVL_W = 6;
    localparam int IDX_W = 7;
    localparam int PRI_W = 6;
    localparam int NL    = 34;
    localparam int NVEC  = 12;

    typedef struct packed {
        logic [18:0]   sw;
        logic [5:0]    lvl;   // 0 = no set command
        logic [6:0]    idx;
        logic [5:0]    ipl;
        logic [1:0]    pc;
        logic          take;
        logic [5:0]    pri;
        logic [NL-1:0] sum;
    } vec_t;

    // Vectors cover R7, R8, R9, R10, R11.
    localparam vec_t TBL [NVEC] = '{
        '{19'h00020, 6'd2,  7'd0,  6'd0,  2'd0, 1'b1, 6'd2,  34'h20},
        '{19'h00410, 6'd2,  7'd5,  6'd0,  2'd0, 1'b1, 6'd7,  34'h410},
        '{19'h40000, 6'd2,  7'd63, 6'd15, 2'd0, 1'b0, 6'd15, 34'h40000},
        '{19'h40000, 6'd2,  7'd63, 6'd14, 2'd0, 1'b1, 6'd15, 34'h40000},
        '{19'h00100, 6'd0,  7'd0,  6'd0,  2'd0, 1'b0, 6'd5,  34'h100},
        '{19'h40000, 6'd25, 7'd40, 6'd0,  2'd0, 1'b1, 6'd25, 34'h2040000},
        '{19'h00000, 6'd33, 7'd1,  6'd0,  2'd1, 1'b0, 6'd33, 34'h200000000},
        '{19'h00000, 6'd33, 7'd1,  6'd32, 2'd0, 1'b1, 6'd33, 34'h200000000},
        '{19'h00000, 6'd20, 7'd0,  6'd20, 2'd0, 1'b0, 6'd20, 34'h100000},
        '{19'h00000, 6'd20, 7'd0,  6'd19, 2'd0, 1'b1, 6'd20, 34'h100000},
        '{19'h00010, 6'd2,  7'd0,  6'd0,  2'd2, 1'b0, 6'd1,  34'h10},
        '{19'h00010, 6'd2,  7'd0,  6'd0,  2'd0, 1'b1, 6'd1,  34'h10}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             post_en = 1'b0, clr_en = 1'b0, clr_all = 1'b0, ack = 1'b0;
    logic [LVL_W-1:0] post_lvl = '0, clr_lvl = '0;
    logic [IDX_W-1:0] post_idx = '0, clr_idx = '0;
    logic [18:0]      sw_req = '0;
    logic [PRI_W-1:0] cur_ipl = '0;
    logic [1:0]       pc_low = '0;
    logic             take_int, cmd_err, ack_err;
    logic [NL-1:0]    level_sum, isr_q;
    logic [PRI_W-1:0] intid_q;

    int n_chk = 0;
    int n_err = 0;

    always #10 clk = ~clk;

    irq_level_ctrl uut (
        .clk(clk), .rst_n(rst_n), .post_en(post_en), .post_lvl(post_lvl),
        .post_idx(post_idx), .clr_en(clr_en), .clr_lvl(clr_lvl),
        .clr_idx(clr_idx), .clr_all(clr_all), .sw_req(sw_req),
        .cur_ipl(cur_ipl), .pc_low(pc_low), .ack(ack), .take_int(take_int),
        .level_sum(level_sum), .isr_q(isr_q), .intid_q(intid_q),
        .cmd_err(cmd_err), .ack_err(ack_err)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_post(input int lvl, input int idx);
        @(negedge clk);
        post_en = 1'b1; post_lvl = LVL_W'(lvl); post_idx = IDX_W'(idx);
        @(negedge clk);
        post_en = 1'b0;
    endtask

    task automatic do_clr(input int lvl, input int idx);
        @(negedge clk);
        clr_en = 1'b1; clr_lvl = LVL_W'(lvl); clr_idx = IDX_W'(idx);
        @(negedge clk);
        clr_en = 1'b0;
    endtask

    task automatic do_wipe();
        @(negedge clk);
        clr_all = 1'b1;
        @(negedge clk);
        clr_all = 1'b0;
    endtask

    task automatic do_ack();
        @(negedge clk);
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R14 reset state
        check("R14 level_sum", 64'(level_sum), 64'h0);
        check("R14 isr_q", 64'(isr_q), 64'h0);
        check("R14 intid_q", 64'(intid_q), 64'h0);
        check("R14 errors", {62'h0, cmd_err, ack_err}, 64'h0);
        check("R14 take_int", 64'(take_int), 64'h0);

        // Table walk: resolution, qualification and commit.
        for (int k = 0; k < NVEC; k++) begin
            sw_req = '0; cur_ipl = '0; pc_low = '0;
            do_wipe();
            if (TBL[k].lvl != 0) do_post(int'(TBL[k].lvl), int'(TBL[k].idx));
            sw_req = TBL[k].sw; cur_ipl = TBL[k].ipl; pc_low = TBL[k].pc;
            #1;
            check($sformatf("R11 R7 take vec %0d", k), 64'(take_int), 64'(TBL[k].take));
            if (TBL[k].take) begin
                @(negedge clk);
                do_ack();
                check($sformatf("R8 R9 intid vec %0d", k), 64'(intid_q), 64'(TBL[k].pri));
                check($sformatf("R10 isr vec %0d", k), 64'(isr_q), 64'(TBL[k].sum));
            end
        end
        sw_req = '0; cur_ipl = '0; pc_low = '0;

        // R9 highest external level wins; R12 commit only on ack.
        do_wipe();
        do_post(21, 2);
        do_post(30, 7);
        #1;
        check("R9 take two levels", 64'(take_int), 64'h1);
        @(negedge clk);
        check("R12 intid held before ack", 64'(intid_q), 64'd1);
        do_ack();
        check("R12 intid after ack", 64'(intid_q), 64'd30);
        check("R12 isr after ack", 64'(isr_q), 64'h40200000);

        // R13 ack without a valid capture.
        do_wipe();
        do_ack();
        do_ack();
        check("R13 ack_err", 64'(ack_err), 64'h1);
        check("R13 intid unchanged", 64'(intid_q), 64'd30);
        check("R13 isr unchanged", 64'(isr_q), 64'h40200000);
        @(negedge clk);
        check("R13 ack_err one cycle", 64'(ack_err), 64'h0);

        // R1 and R2: summary follows the whole word.
        do_wipe();
        do_post(22, 3);
        check("R1 post sets summary", 64'(level_sum), 64'h400000);
        do_post(22, 40);
        do_clr(22, 3);
        check("R2 summary kept", 64'(level_sum), 64'h400000);
        do_clr(22, 40);
        check("R2 summary dropped", 64'(level_sum), 64'h0);

        // R5 upper sources are distinct bits.
        do_post(21, 63);
        check("R5 post 63", 64'(level_sum), 64'h200000);
        do_clr(21, 31);
        check("R5 clear 31 keeps 63", 64'(level_sum), 64'h200000);
        do_clr(21, 63);
        check("R5 clear 63", 64'(level_sum), 64'h0);
        do_post(21, 32);
        do_clr(21, 0);
        check("R5 clear 0 keeps 32", 64'(level_sum), 64'h200000);
        do_clr(21, 32);
        check("R5 clear 32", 64'(level_sum), 64'h0);

        // R4 set and clear of the same source in one cycle.
        @(negedge clk);
        post_en = 1'b1; post_lvl = 6'd23; post_idx = 7'd9;
        clr_en = 1'b1;  clr_lvl = 6'd23;  clr_idx = 7'd9;
        @(negedge clk);
        post_en = 1'b0; clr_en = 1'b0;
        check("R4 set wins", 64'(level_sum), 64'h800000);
        do_clr(23, 9);
        check("R4 single source", 64'(level_sum), 64'h0);

        // R3 wipe overrides a same-cycle set.
        do_post(24, 1);
        @(negedge clk);
        clr_all = 1'b1; post_en = 1'b1; post_lvl = 6'd24; post_idx = 7'd2;
        @(negedge clk);
        clr_all = 1'b0; post_en = 1'b0;
        check("R3 wipe wins", 64'(level_sum), 64'h0);

        // R6 out-of-range commands.
        do_post(40, 0);
        check("R6 bad level err", 64'(cmd_err), 64'h1);
        check("R6 bad level ignored", 64'(level_sum), 64'h0);
        do_post(22, 64);
        check("R6 bad index err", 64'(cmd_err), 64'h1);
        check("R6 bad index ignored", 64'(level_sum), 64'h0);
        do_post(22, 0);
        check("R6 err clears", 64'(cmd_err), 64'h0);
        do_clr(50, 0);
        check("R6 bad clear err", 64'(cmd_err), 64'h1);
        check("R6 bad clear ignored", 64'(level_sum), 64'h400000);

        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule